// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block connects a clocked host to an external asynchronous static RAM of 512K words by 8 bits. The host hands over one access at a time on a valid/ready request channel. The request carries a write flag, a 19-bit word address and the byte to store. The controller turns each request into a timed sequence on the memory pins: active-low chip enable, write enable and output enable, a held address, and a shared 8-bit data bus that the controller drives only while it writes. It then reports completion with a one-cycle response strobe. For a read, that strobe carries the fetched byte.

Every wait is a whole number of clock cycles. Each wait comes from a speed-grade timing set and a clock-period parameter, using ceiling division plus a safety cycle, so the minimum access, pulse, setup and bus-release times hold at any clock rate. A write holds write enable high while the address settles. It then lowers write enable for the write pulse and raises it while chip enable stays low and the data stays driven. When a write directly follows a read, the bus is first given a quiet period so the memory can release it.

Request channel rules: a request transfers on a rising clock edge where both `req_valid` and `req_ready` are high. `req_ready` is high only while no access is in progress. A host may hold `req_valid` high with stable fields while `req_ready` is low, and the request waits. The response channel has no back-pressure: `rsp_valid` is a single-cycle pulse that the host must take when it appears.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `req_ready` is high, the three memory strobes are high, the controller does not drive the bus, and `rsp_valid` is low. `req_ready` goes low in the cycle after an accepting edge and comes back high in the cycle where `rsp_valid` is high.
- R2: A read keeps chip enable and output enable low and write enable high for N_RD cycles, starting the cycle after acceptance, with `mem_addr` equal to the accepted address. N_RD = max(ceil(tCYC/Tclk), ceil(tOE/Tclk)) + 1, which is 8 at the defaults (8000 ps clock, fast grade: tCYC 55 ns, tOE 30 ns).
- R3: Read data is sampled on the edge that ends the last read cycle. `rsp_valid` is then high for exactly one cycle, beginning at the 8th edge after the accepting edge, and `rsp_rdata` equals the stored word.
- R4: A write starts with one setup cycle in which chip enable is low, write enable and output enable are high, and the bus carries the accepted write byte.
- R5: The setup cycle is followed by N_WP cycles with write enable low, chip enable low and output enable high, while the bus is driven. N_WP = max(ceil(tWP/Tclk)+1, ceil(tDW/Tclk)+1, ceil(tCYC/Tclk)), which is 7 at the defaults (tWP 30 ns, tDW 25 ns).
- R6: Write enable rises while chip enable stays low and the data stays driven for one more cycle. After that the memory is deselected and the bus is released. `rsp_valid` pulses once, beginning at the 9th edge after the accepting edge.
- R7: A write whose previous completed access was a read gets N_TURN extra cycles before its setup cycle. In those cycles the memory is deselected, the bus is released and `req_ready` is low. N_TURN = ceil(tOHZ/Tclk) + 1, which is 5 at the defaults (tOHZ 25 ns), so that write's response begins at the 14th edge after acceptance. A write after a write, or the first write after reset, gets no extra cycles.
- R8: Output enable is low only while chip enable is low, write enable is high and the controller's bus driver is off.
- R9: `mem_addr` stays constant for as long as chip enable stays low. The byte on the bus stays constant for as long as the controller keeps driving it.
- R10: The request fields are sampled only at an accepting edge. A `req_valid` held high while `req_ready` is low waits for the idle state. Changes on `req_write`, `req_addr` or `req_wdata` that do not coincide with an acceptance leave the memory pins unchanged, and `mem_addr` keeps the last accepted address while idle.
- R11: A read returns the byte most recently written to that address, including the lowest address 0x00000 and the highest address 0x7FFFF. An address never written reads as the memory's content.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request presented |
| req_ready | output | 1 | Controller idle, request can transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Byte to store on a write |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 8 | Byte fetched by the last read |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 19 | Memory address bus |
| mem_dq | inout | 8 | Shared memory data bus |

## Verification
The properties assume three things about the environment. The memory drives `mem_dq` only while its chip enable and output enable are low and its write enable is high. It stops driving within the bus-release time after output enable rises. The host never needs to stall `rsp_valid`. The bench memory model matches these assumptions: it drives the bus with zero delay, only while the strobes select a read, and it stores the bus value on the rising write-enable edge while chip enable is low. The host stimulus presents requests back to back, after idle gaps, and with fields scrambled while the controller is busy or `req_valid` is low. Against these inputs the bench predicts each clock cycle's strobe, address, bus and response values.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_TURN   = 3'd1,
    ST_RD     = 3'd2,
    ST_WADDR  = 3'd3,
    ST_WPULSE = 3'd4,
    ST_WHOLD  = 3'd5
  } ctl_state_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic drive;
  } pin_set_t;

  localparam pin_set_t PINS_QUIET = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

  // clock cycles that cover a time span (ceiling division)
  function automatic int cycles_for(input int t_ps, input int clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // pin levels held during each phase
  function automatic pin_set_t pins_of(input ctl_state_e st);
    pin_set_t p;
    p = PINS_QUIET;
    case (st)
      ST_RD:     begin p.ce_n = 1'b0; p.oe_n = 1'b0; end
      ST_WADDR:  begin p.ce_n = 1'b0; p.drive = 1'b1; end
      ST_WPULSE: begin p.ce_n = 1'b0; p.we_n = 1'b0; p.drive = 1'b1; end
      ST_WHOLD:  begin p.ce_n = 1'b0; p.drive = 1'b1; end
      default:   p = PINS_QUIET;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
`timescale 1ns/1ps
module sram_wait_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_access_seq.sv
`timescale 1ns/1ps
module sram_access_seq
  import sram_ctrl_pkg::*;
#(
  parameter int N_AS   = 1,
  parameter int N_WP   = 7,
  parameter int N_HOLD = 1,
  parameter int N_RD   = 8,
  parameter int N_TURN = 5,
  parameter int CW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  output logic          req_ready,
  output logic          accept,
  input  logic          tmr_expired,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          capture,
  output pin_set_t      pins,
  output logic          rsp_valid
);

  localparam logic [CW-1:0] LD_AS   = CW'(N_AS - 1);
  localparam logic [CW-1:0] LD_WP   = CW'(N_WP - 1);
  localparam logic [CW-1:0] LD_HOLD = CW'(N_HOLD - 1);
  localparam logic [CW-1:0] LD_RD   = CW'(N_RD - 1);
  localparam logic [CW-1:0] LD_TURN = CW'(N_TURN - 1);

  ctl_state_e state_q, state_d;
  logic       rd_last_q, rd_last_d;
  logic       finish;
  pin_set_t   pins_q;
  logic       rsp_q;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_d   = state_q;
    rd_last_d = rd_last_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    capture   = 1'b0;
    finish    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          tmr_load = 1'b1;
          if (!req_write) begin
            state_d = ST_RD;
            tmr_val = LD_RD;
          end else if (rd_last_q) begin
            state_d = ST_TURN;
            tmr_val = LD_TURN;
          end else begin
            state_d = ST_WADDR;
            tmr_val = LD_AS;
          end
        end
      end
      ST_TURN: begin
        if (tmr_expired) begin
          state_d  = ST_WADDR;
          tmr_load = 1'b1;
          tmr_val  = LD_AS;
        end
      end
      ST_RD: begin
        if (tmr_expired) begin
          state_d   = ST_IDLE;
          capture   = 1'b1;
          finish    = 1'b1;
          rd_last_d = 1'b1;
        end
      end
      ST_WADDR: begin
        if (tmr_expired) begin
          state_d  = ST_WPULSE;
          tmr_load = 1'b1;
          tmr_val  = LD_WP;
        end
      end
      ST_WPULSE: begin
        if (tmr_expired) begin
          state_d  = ST_WHOLD;
          tmr_load = 1'b1;
          tmr_val  = LD_HOLD;
        end
      end
      ST_WHOLD: begin
        if (tmr_expired) begin
          state_d   = ST_IDLE;
          finish    = 1'b1;
          rd_last_d = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rd_last_q <= 1'b0;
      pins_q    <= PINS_QUIET;
      rsp_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      rd_last_q <= rd_last_d;
      pins_q    <= pins_of(state_d);
      rsp_q     <= finish;
    end
  end

  assign pins      = pins_q;
  assign rsp_valid = rsp_q;

endmodule

// File: rtl/sram_data_path.sv
`timescale 1ns/1ps
module sram_data_path #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          capture,
  input  logic [DW-1:0] bus_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= bus_in;
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_PS = 8000,
  parameter bit FAST_GRADE    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq
);

  // timing set in picoseconds, picked by speed grade
  localparam int T_CYC_PS = FAST_GRADE ? 55000 : 70000;
  localparam int T_WP_PS  = FAST_GRADE ? 30000 : 35000;
  localparam int T_DW_PS  = FAST_GRADE ? 25000 : 30000;
  localparam int T_OE_PS  = FAST_GRADE ? 30000 : 35000;
  localparam int T_OHZ_PS = FAST_GRADE ? 25000 : 30000;

  // wait counts in clock cycles, each with a margin cycle
  localparam int N_AS   = cycles_for(0, CLK_PERIOD_PS) + 1;
  localparam int N_HOLD = cycles_for(0, CLK_PERIOD_PS) + 1;
  localparam int N_WP   = max2(max2(cycles_for(T_WP_PS, CLK_PERIOD_PS) + 1,
                                    cycles_for(T_DW_PS, CLK_PERIOD_PS) + 1),
                               cycles_for(T_CYC_PS, CLK_PERIOD_PS) + 1 - N_AS);
  localparam int N_RD   = max2(cycles_for(T_CYC_PS, CLK_PERIOD_PS),
                               cycles_for(T_OE_PS, CLK_PERIOD_PS)) + 1;
  localparam int N_TURN = cycles_for(T_OHZ_PS, CLK_PERIOD_PS) + 1;
  localparam int N_MAX  = max2(max2(N_WP, N_RD), max2(N_TURN, N_AS));
  localparam int CW     = $clog2(N_MAX + 1);

  logic              accept;
  logic              tmr_load;
  logic [CW-1:0]     tmr_val;
  logic              tmr_expired;
  logic              capture;
  pin_set_t          pins;
  logic              dq_drive;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  sram_wait_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_access_seq #(
    .N_AS   (N_AS),
    .N_WP   (N_WP),
    .N_HOLD (N_HOLD),
    .N_RD   (N_RD),
    .N_TURN (N_TURN),
    .CW     (CW)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_ready   (req_ready),
    .accept      (accept),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .capture     (capture),
    .pins        (pins),
    .rsp_valid   (rsp_valid)
  );

  sram_data_path #(.AW(ADDR_W), .DW(DATA_W)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .capture   (capture),
    .bus_in    (mem_dq),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .rdata_q   (rdata_q)
  );

  assign mem_ce_n  = pins.ce_n;
  assign mem_we_n  = pins.we_n;
  assign mem_oe_n  = pins.oe_n;
  assign dq_drive  = pins.drive;
  assign mem_addr  = addr_q;
  assign rsp_rdata = rdata_q;
  assign mem_dq    = dq_drive ? wdata_q : {DATA_W{1'bz}};

endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic [AW-1:0] mem_addr,
  input logic          dq_drive,
  input logic [DW-1:0] dq_word
);

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !dq_drive)); // R1

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R3

  AST_PULSE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && dq_drive)); // R5

  AST_WE_END_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce_n && dq_drive)); // R6

  AST_DRIVE_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_drive) |-> $past(mem_oe_n)); // R7

  AST_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n && !dq_drive)); // R8

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R9

  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_drive && $past(dq_drive)) |-> $stable(dq_word)); // R9

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_addr  (mem_addr),
  .dq_drive  (dq_drive),
  .dq_word   (wdata_q)
);

// File: tb/sim_sram_async_ctrl.sv
`timescale 1ns/1ps
module sim_sram_async_ctrl;

  localparam int N_RD   = 8;
  localparam int N_WP   = 7;
  localparam int N_TURN = 5;
  localparam int WDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        mem_ce_n, mem_we_n, mem_oe_n;
  logic [18:0] mem_addr;
  wire  [7:0]  dq_bus;

  always #4 clk = ~clk;

  sram_async_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_dq(dq_bus)
  );

  // behavioural memory device
  logic [7:0] sram [logic [18:0]];
  logic [7:0] rd_word = 8'h00;
  logic       rd_en;
  assign rd_en  = (mem_ce_n === 1'b0) && (mem_we_n === 1'b1) && (mem_oe_n === 1'b0);
  assign dq_bus = rd_en ? rd_word : 8'hzz;

  always @(mem_addr or mem_ce_n or mem_oe_n or mem_we_n)
    rd_word = sram.exists(mem_addr) ? sram[mem_addr] : 8'h00;

  always @(posedge mem_we_n)
    if (mem_ce_n === 1'b0) sram[mem_addr] = dq_bus;

  // bookkeeping
  int n_checks = 0;
  int n_err    = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  typedef struct {
    bit wr; logic [18:0] addr; logic [7:0] data; int gap;
  } op_t;

  typedef struct {
    bit ce; bit we; bit oe; bit drv; bit rdy; bit done; bit isrd;
    logic [18:0] addr; logic [7:0] wd; logic [7:0] rd;
    string tag; string atag;
  } exp_t;

  op_t         stims[$];
  exp_t        expq[$];
  logic [7:0]  ref_mem [logic [18:0]];
  logic [18:0] last_addr = '0;
  bit          last_rd = 1'b0;
  op_t         cur;
  int          sidx = 0;
  int          gap_left = 0;
  bit          stim_done = 1'b0;
  bit          acc_pending = 1'b0;
  bit          started = 1'b0;
  bit          running = 1'b0;
  bit          finished = 1'b0;
  int          tail = 0;
  logic [31:0] seed = 32'h1badf00d;

  function automatic exp_t mk(bit ce, bit we, bit oe, bit drv, bit rdy, bit done,
                              bit isrd, logic [18:0] a, logic [7:0] wd,
                              logic [7:0] rd, string tag, string atag);
    exp_t e;
    e.ce = ce; e.we = we; e.oe = oe; e.drv = drv; e.rdy = rdy; e.done = done;
    e.isrd = isrd; e.addr = a; e.wd = wd; e.rd = rd; e.tag = tag; e.atag = atag;
    return e;
  endfunction

  task automatic push_op(input op_t o);
    logic [7:0] rv;
    if (o.wr) begin
      if (last_rd)
        for (int i = 0; i < N_TURN; i++)
          expq.push_back(mk(1, 1, 1, 0, 0, 0, 0, o.addr, o.data, 0, "R7", "R7"));
      expq.push_back(mk(0, 1, 1, 1, 0, 0, 0, o.addr, o.data, 0, "R4", "R4"));
      for (int i = 0; i < N_WP; i++)
        expq.push_back(mk(0, 0, 1, 1, 0, 0, 0, o.addr, o.data, 0, "R5", "R9"));
      expq.push_back(mk(0, 1, 1, 1, 0, 0, 0, o.addr, o.data, 0, "R6", "R9"));
      expq.push_back(mk(1, 1, 1, 0, 1, 1, 0, o.addr, o.data, 0, "R6", "R10"));
      ref_mem[o.addr] = o.data;
      last_rd = 1'b0;
    end else begin
      rv = ref_mem.exists(o.addr) ? ref_mem[o.addr] : 8'h00;
      for (int i = 0; i < N_RD; i++)
        expq.push_back(mk(0, 1, 0, 0, 0, 0, 0, o.addr, 0, 0, "R2", "R9"));
      expq.push_back(mk(1, 1, 1, 0, 1, 1, 1, o.addr, 0, rv, "R3", "R10"));
      last_rd = 1'b1;
    end
    last_addr = o.addr;
  endtask

  task automatic scramble();
    seed = seed * 32'd1103515245 + 32'd12345;
    req_write = seed[5];
    req_addr  = seed[30:12];
    req_wdata = seed[11:4];
  endtask

  task automatic present();
    req_valid = 1'b1;
    req_write = cur.wr;
    req_addr  = cur.addr;
    req_wdata = cur.data;
  endtask

  task automatic load_next();
    if (sidx >= stims.size()) begin
      req_valid = 1'b0;
      stim_done = 1'b1;
    end else begin
      cur = stims[sidx];
      sidx++;
      if (cur.gap == 0) present();
      else begin
        req_valid = 1'b0;
        scramble();
        gap_left = cur.gap;
      end
    end
  endtask

  task automatic compare(input exp_t e);
    chk({mem_ce_n, mem_we_n, mem_oe_n} === {e.ce, e.we, e.oe}, e.tag, "strobes",
        {mem_ce_n, mem_we_n, mem_oe_n}, {e.ce, e.we, e.oe});
    chk(req_ready === e.rdy, (e.tag == "R7") ? "R7" : "R1", "req_ready", req_ready, e.rdy);
    chk(rsp_valid === e.done, e.tag, "rsp_valid", rsp_valid, e.done);
    chk(mem_addr === e.addr, e.atag, "mem_addr", mem_addr, e.addr);
    if (e.done && e.isrd)
      chk(rsp_rdata === e.rd, "R3/R11", "rsp_rdata", rsp_rdata, e.rd);
    if (e.drv) begin
      chk(dq_bus === e.wd, e.atag, "bus byte", dq_bus, e.wd);
      chk(mem_oe_n === 1'b1, "R8", "oe while driving", mem_oe_n, 1);
    end
  endtask

  // cycle-by-cycle model, compared at every falling edge
  always @(negedge clk) begin
    exp_t e;
    if (running && !finished) begin
      if (!started) begin
        started = 1'b1;
        load_next();
      end else if (acc_pending) begin
        push_op(cur);
        load_next();
      end else if (gap_left > 0) begin
        gap_left--;
        if (gap_left == 0) present();
        else scramble();
      end
      if (expq.size() > 0) e = expq.pop_front();
      else e = mk(1, 1, 1, 0, 1, 0, 0, last_addr, 0, 0, "R1", "R10");
      compare(e);
      acc_pending = req_valid && e.rdy;
      if (stim_done && expq.size() == 0 && !acc_pending) begin
        tail++;
        if (tail >= 4) finished = 1'b1;
      end
    end
  end

  function automatic op_t mkop(bit wr, logic [18:0] a, logic [7:0] d, int gap);
    op_t o;
    o.wr = wr; o.addr = a; o.data = d; o.gap = gap;
    return o;
  endfunction

  initial begin
    logic [31:0] s;
    int cyc;
    // directed: edges of address space, back-to-back, turnaround (R7, R11)
    stims.push_back(mkop(1, 19'h00000, 8'h5A, 2));
    stims.push_back(mkop(1, 19'h7FFFF, 8'hC3, 0));
    stims.push_back(mkop(0, 19'h00000, 8'h00, 0));
    stims.push_back(mkop(1, 19'h12345, 8'h81, 0));
    stims.push_back(mkop(0, 19'h7FFFF, 8'h00, 3));
    stims.push_back(mkop(0, 19'h12345, 8'h00, 0));
    stims.push_back(mkop(0, 19'h00001, 8'h00, 0));
    stims.push_back(mkop(1, 19'h00001, 8'hFF, 10));
    stims.push_back(mkop(0, 19'h00001, 8'h00, 0));
    stims.push_back(mkop(1, 19'h00000, 8'h00, 1));
    stims.push_back(mkop(0, 19'h00000, 8'h00, 0));
    // mixed traffic over a small address pool (R10, R11)
    s = 32'h2468ace1;
    for (int i = 0; i < 40; i++) begin
      logic [18:0] a;
      s = s * 32'd1664525 + 32'd1013904223;
      a = (s[10:8] == 3'd7) ? 19'h7FFFF : {16'h0, s[10:8]};
      stims.push_back(mkop(s[3], a, s[23:16], int'(s[13:12])));
    end

    // reset state (R1)
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R1", "ready in reset", req_ready, 1);
    chk({mem_ce_n, mem_we_n, mem_oe_n} === 3'b111, "R1", "strobes in reset",
        {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
    chk(rsp_valid === 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(posedge clk);
    running = 1'b1;

    cyc = 0;
    while (!finished && cyc < WDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      n_checks++;
      n_err++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, WDOG);
    end
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

endmodule